// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single access requests from inside a chip into bus cycles on an external processor-style bus. The bus has an 8-bit data path and a 20-bit address, and it saves pins by sharing them. The low eight pins carry the low address byte first and data afterwards. The top four pins carry the high address nibble first and a status code afterwards. A request names the access kind (memory or port, read or write), the address, the write byte, a two-bit segment selector and the interrupt-enable flag. The block then walks the bus through the clock states T1, T2, T3 and T4. Between T3 and T4 it adds wait states for as long as the external ready input stays low.

Another master can take the bus with a hold request. The block grants it only at a cycle boundary, either while idle or directly after T4. While the grant is active, every address, status and control output is released. Each three-state pin is modelled as a value output plus an enable output, so the block stays synthesizable and the pad ring supplies the actual buffers.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `ale_o` is 1, `ad_o` carries address bits 7..0 with `ad_oe` set, and `amid_o` carries address bits 15..8.
- R2: In T1, `ahi_o` carries address bits 19..16 for a memory access and 4'b0000 for a port access.
- R3: From T2 through T4, `ahi_o` is {1'b0, interrupt-enable, segment[1:0]}, with segment codes 0=extra, 1=stack, 2=code, 3=data.
- R4: The levels of (`io_m_o`, `wr_n_o`, `rd_n_o`) are: memory read 0,1,0; memory write 0,0,1; port read 1,1,0; port write 1,0,1. The active strobe is low from T2 to the end of the last T3 or wait state. It is high in T1, in T4 and while idle.
- R5: With `ready_in` high during T3, the cycle takes exactly four clocks (T1..T4). Each clock in T3 or in a wait state with `ready_in` low adds one wait state, and `ready_in` is sampled again in every wait state.
- R6: `den_n_o` is low from T2 through T4. A write drives `wdata` on `ad_o` with `ad_oe` high and `dtr_o`=1. A read keeps `ad_oe` low with `dtr_o`=0.
- R7: A read captures `ad_i` at the clock edge that ends the final T3 or wait state. `rsp_done` is high for exactly the T4 clock, with `rsp_rdata` valid during it.
- R8: `req_ready` is high only while idle with `hold_in` low. A request taken at an edge starts T1 in the next clock.
- R9: When `hold_in` is high while idle or in T4, `hlda_o` is 1 from the next clock. While `hlda_o` is 1, `bus_oe`, `ad_oe` and `req_ready` are 0. A hold raised mid-cycle waits until T4 completes.
- R10: After `hold_in` falls, `hlda_o` drops and `bus_oe` returns in the next clock, and requests are accepted again.
- R11: After reset the block is idle: `hlda_o`=0, `ale_o`=0, `rd_n_o`=`wr_n_o`=`den_n_o`=1, `rsp_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_io | input | 1 | 1 = port access, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 8 | Write byte |
| req_seg | input | 2 | Segment selector code |
| req_ie | input | 1 | Interrupt-enable flag for status |
| rsp_done | output | 1 | Cycle in T4 / completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| ready_in | input | 1 | External ready, high = proceed |
| hold_in | input | 1 | External bus request |
| hlda_o | output | 1 | Bus released acknowledge |
| ad_o | output | 8 | Shared address/data pin values |
| ad_oe | output | 1 | Enable for ad_o |
| ad_i | input | 8 | Shared address/data pin input |
| amid_o | output | 8 | Address bits 15..8 |
| ahi_o | output | 4 | Shared high-address/status pin values |
| bus_oe | output | 1 | Enable for address, status and control pins |
| ale_o | output | 1 | Address latch strobe |
| io_m_o | output | 1 | 1 = port access, 0 = memory |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dtr_o | output | 1 | Data direction, 1 = transmit |
| den_n_o | output | 1 | Data enable, active low |

## Verification
Every pin level is decoded from the registered state, so it is due in the clock that follows the edge that entered that state. T1 follows the accepting edge by one clock, and each of T2, T3, the wait states and T4 takes one further clock. `rsp_done` and the read byte appear in the clock after the edge that saw `ready_in` high, and `hlda_o` follows the edge that saw `hold_in` by one clock. The bench changes inputs and samples outputs only on falling edges, so it checks each state in its own clock and sets `ready_in` before the rising edge that samples it.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_state_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_STACK = 2'd1,
    SEG_CODE  = 2'd2,
    SEG_DATA  = 2'd3
  } seg_e;

  localparam int unsigned STAT_W = 4;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_seg,
  input  logic              req_ie,
  input  logic              ready_in,
  input  logic              hold_in,
  input  logic [DATA_W-1:0] bus_din,
  output bus_state_e        state_o,
  output logic              lat_io,
  output logic              lat_write,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [1:0]        lat_seg,
  output logic              lat_ie,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  bus_state_e state_q, state_d;
  logic accept, capture;
  logic done_q;
  logic [DATA_W-1:0] rdata_q;
  logic io_q, write_q, ie_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0] seg_q;

  assign req_ready = (state_q == ST_IDLE) && !hold_in;
  assign accept    = req_valid && req_ready;
  assign capture   = ((state_q == ST_T3) || (state_q == ST_TW)) && ready_in;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_in)        state_d = ST_HOLD;
        else if (req_valid) state_d = ST_T1;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready_in ? ST_T4 : ST_TW;
      ST_T4:   state_d = hold_in ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_d = hold_in ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= capture;
    end
  end

  // request holding register, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q    <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      seg_q   <= 2'b00;
      ie_q    <= 1'b0;
    end else if (accept) begin
      io_q    <= req_io;
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      seg_q   <= req_seg;
      ie_q    <= req_ie;
    end
  end

  // read byte capture at the edge ending the last T3/wait state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rdata_q <= '0;
    else if (capture && !write_q) rdata_q <= bus_din;
  end

  assign state_o   = state_q;
  assign lat_io    = io_q;
  assign lat_write = write_q;
  assign lat_addr  = addr_q;
  assign lat_wdata = wdata_q;
  assign lat_seg   = seg_q;
  assign lat_ie    = ie_q;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  // R8
  accept_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (state_q == ST_T1));

  // R5
  wait_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TW) |-> (($past(state_q) == ST_T3 || $past(state_q) == ST_TW) && !$past(ready_in)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) != ST_HOLD) |->
      (($past(state_q) == ST_IDLE || $past(state_q) == ST_T4) && $past(hold_in)));

endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state_i,
  input  logic              lat_io,
  input  logic              lat_write,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  input  logic [1:0]        lat_seg,
  input  logic              lat_ie,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-STAT_W-1:0] amid_o,
  output logic [STAT_W-1:0] ahi_o,
  output logic              bus_oe,
  output logic              ale_o,
  output logic              io_m_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dtr_o,
  output logic              den_n_o,
  output logic              hlda_o
);

  localparam int unsigned MID_W = ADDR_W - DATA_W - STAT_W;
  localparam int unsigned HI_LO = ADDR_W - STAT_W;

  logic in_t1, in_data, in_strobe, in_hold;
  logic [STAT_W-1:0] status_code;
  logic [STAT_W-1:0] hi_addr;

  assign in_t1     = (state_i == ST_T1);
  assign in_data   = (state_i == ST_T2) || (state_i == ST_T3) ||
                     (state_i == ST_TW) || (state_i == ST_T4);
  assign in_strobe = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign in_hold   = (state_i == ST_HOLD);

  // status: top bit fixed low, then interrupt enable, then segment code
  assign status_code = {1'b0, lat_ie, lat_seg};
  // port cycles carry a 16-bit address, so the top nibble is zero
  assign hi_addr     = lat_io ? '0 : lat_addr[ADDR_W-1:HI_LO];

  generate
    if (MID_W > 0) begin : g_mid
      assign amid_o = (in_t1 || in_data) ? lat_addr[HI_LO-1:DATA_W] : '0;
    end else begin : g_nomid
      assign amid_o = '0;
    end
  endgenerate

  always_comb begin
    ad_o    = '0;
    ad_oe   = 1'b0;
    ahi_o   = '0;
    ale_o   = 1'b0;
    io_m_o  = 1'b0;
    rd_n_o  = 1'b1;
    wr_n_o  = 1'b1;
    dtr_o   = 1'b1;
    den_n_o = 1'b1;
    if (in_t1) begin
      ad_o   = lat_addr[DATA_W-1:0];
      ad_oe  = 1'b1;
      ahi_o  = hi_addr;
      ale_o  = 1'b1;
      io_m_o = lat_io;
      dtr_o  = lat_write;
    end else if (in_data) begin
      ad_o    = lat_write ? lat_wdata : '0;
      ad_oe   = lat_write;
      ahi_o   = status_code;
      io_m_o  = lat_io;
      dtr_o   = lat_write;
      den_n_o = 1'b0;
      rd_n_o  = !(in_strobe && !lat_write);
      wr_n_o  = !(in_strobe && lat_write);
    end
  end

  assign bus_oe = !in_hold;
  assign hlda_o = in_hold;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R1
  ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (ad_oe && bus_oe));

  // R6
  read_noconflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n_o && !dtr_o) |-> !ad_oe);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> (!bus_oe && !ad_oe));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_seg,
  input  logic              req_ie,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ready_in,
  input  logic              hold_in,
  output logic              hlda_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-DATA_W-4-1:0] amid_o,
  output logic [3:0]        ahi_o,
  output logic              bus_oe,
  output logic              ale_o,
  output logic              io_m_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              dtr_o,
  output logic              den_n_o
);

  bus_state_e        state;
  logic              lat_io, lat_write, lat_ie;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [1:0]        lat_seg;

  mbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_io    (req_io),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_seg   (req_seg),
    .req_ie    (req_ie),
    .ready_in  (ready_in),
    .hold_in   (hold_in),
    .bus_din   (ad_i),
    .state_o   (state),
    .lat_io    (lat_io),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .lat_seg   (lat_seg),
    .lat_ie    (lat_ie),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (state),
    .lat_io    (lat_io),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .lat_seg   (lat_seg),
    .lat_ie    (lat_ie),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .amid_o    (amid_o),
    .ahi_o     (ahi_o),
    .bus_oe    (bus_oe),
    .ale_o     (ale_o),
    .io_m_o    (io_m_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .dtr_o     (dtr_o),
    .den_n_o   (den_n_o),
    .hlda_o    (hlda_o)
  );

  // R10
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hlda_o)) |-> (bus_oe && !$past(hold_in)));

endmodule

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_io, req_write, req_ie;
  logic [19:0] req_addr;
  logic [7:0] req_wdata, rsp_rdata, ad_o, ad_i, amid_o;
  logic [1:0] req_seg;
  logic rsp_done, ready_in, hold_in, hlda_o, ad_oe, bus_oe;
  logic [3:0] ahi_o;
  logic ale_o, io_m_o, rd_n_o, wr_n_o, dtr_o, den_n_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mux_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ready_in(ready_in),
    .hold_in(hold_in), .hlda_o(hlda_o), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .amid_o(amid_o), .ahi_o(ahi_o), .bus_oe(bus_oe),
    .ale_o(ale_o), .io_m_o(io_m_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .dtr_o(dtr_o), .den_n_o(den_n_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 0; req_io = 0; req_write = 0; req_addr = '0;
    req_wdata = '0; req_seg = 0; req_ie = 0; ready_in = 1; hold_in = 0; ad_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk("R11", "hlda", hlda_o, 0);
    chk("R11", "ale", ale_o, 0);
    chk("R11", "rd_n/wr_n/den_n", {rd_n_o, wr_n_o, den_n_o}, 3'b111);
    chk("R11", "done", rsp_done, 0);
    chk("R8", "ready idle", req_ready, 1);
  endtask

  task automatic t_cycle(input logic io, input logic wr, input logic [19:0] addr,
                         input logic [7:0] wd, input logic [1:0] seg, input logic ie,
                         input int waits, input logic [7:0] rd);
    logic [3:0] stat;
    stat = {1'b0, ie, seg};
    @(negedge clk);
    req_valid = 1; req_io = io; req_write = wr; req_addr = addr;
    req_wdata = wd; req_seg = seg; req_ie = ie;
    chk("R8", "req_ready before accept", req_ready, 1);
    @(negedge clk);                         // T1
    req_valid = 0; ad_i = rd;
    chk("R1", "ale in T1", ale_o, 1);
    chk("R1", "ad low address", {ad_oe, ad_o}, {1'b1, addr[7:0]});
    chk("R1", "mid address", amid_o, addr[15:8]);
    chk("R2", "high nibble T1", ahi_o, io ? 4'h0 : addr[19:16]);
    chk("R4", "T1 strobes idle", {io_m_o, wr_n_o, rd_n_o}, {io, 2'b11});
    @(negedge clk);                         // T2
    chk("R3", "status T2", ahi_o, stat);
    chk("R4", "T2 levels", {io_m_o, wr_n_o, rd_n_o}, {io, !wr, wr});
    chk("R6", "T2 den/dtr/oe", {den_n_o, dtr_o, ad_oe}, {1'b0, wr, wr});
    if (wr) chk("R6", "write data T2", ad_o, wd);
    chk("R1", "ale low T2", ale_o, 0);
    @(negedge clk);                         // T3
    ready_in = (waits == 0);
    chk("R4", "T3 levels", {io_m_o, wr_n_o, rd_n_o}, {io, !wr, wr});
    chk("R5", "no done T3", rsp_done, 0);
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);                       // wait state
      ready_in = (i == waits);
      chk("R5", "strobe held in wait", {wr_n_o, rd_n_o}, {!wr, wr});
      chk("R5", "no done in wait", rsp_done, 0);
    end
    @(negedge clk);                         // T4
    ready_in = 1; ad_i = 8'h00;
    chk("R7", "done in T4", rsp_done, 1);
    chk("R4", "T4 strobes off", {wr_n_o, rd_n_o}, 2'b11);
    chk("R6", "den T4", den_n_o, 0);
    chk("R3", "status T4", ahi_o, stat);
    if (!wr) chk("R7", "read data", rsp_rdata, rd);
    else     chk("R6", "write data T4", {ad_oe, ad_o}, {1'b1, wd});
    @(negedge clk);                         // idle
    chk("R7", "done one clock", rsp_done, 0);
    chk("R8", "ready after cycle", req_ready, 1);
  endtask

  task automatic t_hold_idle();
    @(negedge clk);
    hold_in = 1;
    @(negedge clk);
    chk("R9", "hlda from idle", hlda_o, 1);
    chk("R9", "released", {bus_oe, ad_oe, req_ready}, 3'b000);
    req_valid = 1; req_addr = 20'h12345;
    @(negedge clk);
    chk("R9", "no cycle during hold", {hlda_o, bus_oe}, 2'b10);
    req_valid = 0;
    hold_in = 0;
    @(negedge clk);
    chk("R10", "hlda dropped", {hlda_o, bus_oe, req_ready}, 3'b011);
    chk("R10", "no stray ale", ale_o, 0);
  endtask

  task automatic t_hold_mid();
    @(negedge clk);
    req_valid = 1; req_io = 0; req_write = 0; req_addr = 20'hA0F0C;
    req_seg = 2'd1; req_ie = 0;
    @(negedge clk);                         // T1
    req_valid = 0; hold_in = 1;
    @(negedge clk);                         // T2
    chk("R9", "hold deferred T2", {hlda_o, bus_oe}, 2'b01);
    @(negedge clk);                         // T3
    chk("R9", "hold deferred T3", hlda_o, 0);
    @(negedge clk);                         // T4
    chk("R9", "hold deferred T4", {hlda_o, rsp_done}, 2'b01);
    @(negedge clk);
    chk("R9", "hlda after T4", {hlda_o, bus_oe}, 2'b10);
    hold_in = 0;
    @(negedge clk);
    chk("R10", "bus back", {hlda_o, bus_oe}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_cycle(1'b0, 1'b0, 20'hF3C5A, 8'h00, 2'd2, 1'b1, 0, 8'h96);  // memory read
    t_cycle(1'b0, 1'b1, 20'h5A1E7, 8'hC3, 2'd3, 1'b0, 2, 8'h00);  // memory write, waits
    t_cycle(1'b1, 1'b0, 20'h9BEEF, 8'h00, 2'd0, 1'b1, 1, 8'h3C);  // port read
    t_cycle(1'b1, 1'b1, 20'h0F00D, 8'h5A, 2'd1, 1'b0, 0, 8'h00);  // port write
    t_cycle(1'b0, 1'b0, 20'h80001, 8'h00, 2'd1, 1'b1, 3, 8'hE1);  // long wait read
    t_hold_idle();
    t_hold_mid();
    t_cycle(1'b0, 1'b1, 20'h7FFFF, 8'hFF, 2'd0, 1'b1, 0, 8'h00);  // after hold
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule